// File: doc/BRIEF.md
# CAN Node Error State Monitor

This block watches the receive and transmit error counters of a CAN protocol engine and sorts the node into one of four fault-confinement states: error-active, warning, passive or bus-off. The state is derived each cycle from counter thresholds and held in a register. A one-cycle pulse marks every change of state.

A status word records which state was most recently entered, and which frame-level error types were seen. Every status bit is sticky and clears when the status word is read. The block also keeps a mask of state-change interrupts. After each transition the mask is narrowed to the single next transition of interest. An interrupt line collects the enabled state entries and any recorded frame error.

A host reads the counter word and the status word through a surrounding register interface. It pulses the read strobe when it consumes the status word.

Top module: `can_err_state_mon`

## Requirements
- R1: After reset the node state is error-active (code 0), the status word is zero, the interrupt line is low and no state-change pulse is present.
- R2: The state is error-active (code 0) when both counters are below 96, and warning (code 1) when both counters are below 128 but at least one is 96 or more.
- R3: The state is passive (code 2) when both counters are below 256 but at least one is 128 or more, and bus-off (code 3) otherwise. Only the 9-bit transmit counter can reach 256.
- R4: The counter word carries the receive counter in bits 7:0 and the transmit counter in bits 24:16 (its low 8 bits in 23:16, its ninth bit in 24). All other bits are zero.
- R5: `state_chg` is high in exactly the cycle where the classified state differs from the registered state. The registered state takes the new value at the next clock edge.
- R6: Entering a state sets status bit 16 plus the state code: 16 for error-active, 17 for warning, 18 for passive, 19 for bus-off.
- R7: A pulse on `frame_err[i]` sets status bit 24+i. In index order 0 to 4 these are CRC, stuffing, acknowledge, form and bit errors.
- R8: A read strobe clears all status bits at the next edge. An event in the same cycle as the read is kept set.
- R9: While the node is error-active or warning, only entry into passive is enabled as an interrupt. While it is passive, only entry into bus-off is enabled. In bus-off, no state entry is enabled. The mask that applies is the one of the state being left.
- R10: `irq` is high while an enabled state entry is pending or any frame-error status bit is set. A read clears the pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_err_cnt | input | 8 | Receive error counter from the protocol engine |
| tx_err_cnt | input | 9 | Transmit error counter from the protocol engine |
| frame_err | input | 5 | Frame error event pulses (CRC, stuff, ack, form, bit) |
| status_rd | input | 1 | Status word read strobe |
| node_state | output | 2 | Registered fault-confinement state |
| state_chg | output | 1 | One-cycle pulse on a state change |
| status_word | output | 32 | Sticky status bits |
| err_cnt_word | output | 32 | Packed counter word |
| irq | output | 1 | Interrupt line |

## Verification
A wrong registered state shows on `node_state` at the edge after the counters move. One cycle later it also shows as a missing or extra `state_chg` pulse, because the comparison stays unbalanced. A mask that tracks the wrong state shows as `irq` rising, or failing to rise, right after the edge that enters passive or bus-off.

A read that clears too much, or too little, shows in the next cycle's status word. So does any event that is lost in the same cycle as a read.

// File: rtl/can_esm_pkg.sv
package can_esm_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'd0,
      ST_WARN    = 2'd1,
      ST_PASSIVE = 2'd2,
      ST_BUSOFF  = 2'd3
   } node_state_e;

   localparam int STATUS_W      = 32;
   localparam int STAT_STATE_LO = 16;
   localparam int STAT_FERR_LO  = 24;
   localparam int N_FERR        = 5;
endpackage

// File: rtl/esm_classify.sv
module esm_classify
   import can_esm_pkg::*;
#(
   parameter int RX_W     = 8,
   parameter int TX_W     = 9,
   parameter int WARN_LIM = 96,
   parameter int PASS_LIM = 128,
   parameter int BOFF_LIM = 256
) (
   input  logic [RX_W-1:0] rx_cnt,
   input  logic [TX_W-1:0] tx_cnt,
   output node_state_e     cls
);
   localparam int CW = 32;

   logic [CW-1:0] rx_x, tx_x;
   assign rx_x = CW'(rx_cnt);
   assign tx_x = CW'(tx_cnt);

   initial begin
      assert (WARN_LIM < PASS_LIM && PASS_LIM < BOFF_LIM)
         else $fatal(1, "esm_classify: thresholds must ascend");
   end

   always_comb begin
      if (rx_x < CW'(WARN_LIM) && tx_x < CW'(WARN_LIM))
         cls = ST_ACTIVE;
      else if (rx_x < CW'(PASS_LIM) && tx_x < CW'(PASS_LIM))
         cls = ST_WARN;
      else if (rx_x < CW'(BOFF_LIM) && tx_x < CW'(BOFF_LIM))
         cls = ST_PASSIVE;
      else
         cls = ST_BUSOFF;
   end
endmodule

// File: rtl/esm_state_track.sv
module esm_state_track
   import can_esm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  node_state_e cls,
   output node_state_e state_q,
   output logic        chg,
   output logic [3:0]  ien,
   output logic        entry_irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_ACTIVE;
      else        state_q <= cls;
   end

   assign chg = (cls != state_q);

   // next reachable transition only
   always_comb begin
      ien = 4'b0000;
      unique case (state_q)
         ST_ACTIVE, ST_WARN: ien[ST_PASSIVE] = 1'b1;
         ST_PASSIVE:         ien[ST_BUSOFF]  = 1'b1;
         default:            ien = 4'b0000;
      endcase
   end

   assign entry_irq = chg & ien[cls];

   a_r5_chg_lands: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (state_q != $past(state_q)));
   a_r5_no_chg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !chg |=> $stable(state_q));
   a_r9_mask_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ien));
   a_r9_busoff_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSOFF) |-> (ien == 4'b0000));
endmodule

// File: rtl/esm_status.sv
module esm_status
   import can_esm_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  logic                chg,
   input  node_state_e         cls,
   input  logic                entry_irq,
   input  logic [N_FERR-1:0]   fe,
   output logic [STATUS_W-1:0] status_q,
   output logic                pend_q
);
   logic [STATUS_W-1:0] set_v;
   logic [STATUS_W-1:0] status_d;

   always_comb begin
      set_v = '0;
      if (chg) set_v[STAT_STATE_LO + int'(cls)] = 1'b1;
   end

   for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
      if (i >= STAT_FERR_LO && i < STAT_FERR_LO + N_FERR) begin : g_fe
         assign status_d[i] = fe[i-STAT_FERR_LO] | (status_q[i] & ~rd);
      end else if (i >= STAT_STATE_LO && i < STAT_STATE_LO + 4) begin : g_st
         assign status_d[i] = set_v[i] | (status_q[i] & ~rd);
      end else begin : g_zero
         assign status_d[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         pend_q   <= 1'b0;
      end else begin
         status_q <= status_d;
         pend_q   <= entry_irq | (pend_q & ~rd);
      end
   end

   a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((status_q & $past(status_q)) == $past(status_q)));
   a_r6_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> status_q[STAT_STATE_LO + int'($past(cls))]);
   a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !rd) |=> pend_q);
endmodule

// File: rtl/can_err_state_mon.sv
module can_err_state_mon
   import can_esm_pkg::*;
#(
   parameter int RX_W     = 8,
   parameter int TX_W     = 9,
   parameter int WARN_LIM = 96,
   parameter int PASS_LIM = 128,
   parameter int BOFF_LIM = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RX_W-1:0]     rx_err_cnt,
   input  logic [TX_W-1:0]     tx_err_cnt,
   input  logic [N_FERR-1:0]   frame_err,
   input  logic                status_rd,
   output logic [1:0]          node_state,
   output logic                state_chg,
   output logic [STATUS_W-1:0] status_word,
   output logic [31:0]         err_cnt_word,
   output logic                irq
);
   localparam int TX_LO = 16;

   initial begin
      assert (RX_W <= TX_LO && TX_W <= 32 - TX_LO)
         else $fatal(1, "can_err_state_mon: counter widths exceed word");
   end

   node_state_e cls, state_q;
   logic        chg, entry_irq, pend_q;
   logic [3:0]  ien;
   logic [STATUS_W-1:0] status_q;

   esm_classify #(
      .RX_W(RX_W), .TX_W(TX_W), .WARN_LIM(WARN_LIM),
      .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
   ) u_cls (
      .rx_cnt(rx_err_cnt), .tx_cnt(tx_err_cnt), .cls(cls)
   );

   esm_state_track u_trk (
      .clk(clk), .rst_n(rst_n), .cls(cls), .state_q(state_q),
      .chg(chg), .ien(ien), .entry_irq(entry_irq)
   );

   esm_status u_sts (
      .clk(clk), .rst_n(rst_n), .rd(status_rd), .chg(chg), .cls(cls),
      .entry_irq(entry_irq), .fe(frame_err), .status_q(status_q),
      .pend_q(pend_q)
   );

   always_comb begin
      err_cnt_word = '0;
      err_cnt_word[RX_W-1:0]        = rx_err_cnt;
      err_cnt_word[TX_LO +: TX_W]   = tx_err_cnt;
   end

   assign node_state  = state_q;
   assign state_chg   = chg;
   assign status_word = status_q;
   assign irq         = pend_q | (|status_q[STAT_FERR_LO +: N_FERR]);

   a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|status_word));
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (status_word == '0 && node_state == 2'd0));
endmodule

// File: tb/sim_can_err_state_mon.sv
`timescale 1ns/1ps
module sim_can_err_state_mon;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx = '0;
   logic [8:0]  tx = '0;
   logic [4:0]  fe = '0;
   logic        rd = 1'b0;
   logic [1:0]  node_state;
   logic        state_chg;
   logic [31:0] status_word, err_cnt_word;
   logic        irq;

   always #5 clk = ~clk;

   can_err_state_mon u0 (
      .clk(clk), .rst_n(rst_n), .rx_err_cnt(rx), .tx_err_cnt(tx),
      .frame_err(fe), .status_rd(rd), .node_state(node_state),
      .state_chg(state_chg), .status_word(status_word),
      .err_cnt_word(err_cnt_word), .irq(irq)
   );

   typedef struct {
      logic        chg;
      logic [1:0]  st;
      logic [31:0] stat;
      logic        irq;
      logic [31:0] cw;
   } item_t;

   item_t exp_q[$];
   string tag_q[$];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model
   logic [1:0]  m_st = 2'd0;
   logic [31:0] m_stat = '0;
   logic        m_pend = 1'b0;

   function automatic logic [1:0] classify(int r, int t);
      if (r < 96 && t < 96)   return 2'd0;
      if (r < 128 && t < 128) return 2'd1;
      if (r < 256 && t < 256) return 2'd2;
      return 2'd3;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(string req, int r, int t, logic [4:0] f, logic rdv);
      item_t it;
      logic [1:0] c;
      logic [3:0] mask;
      @(negedge clk);
      rx = r[7:0]; tx = t[8:0]; fe = f; rd = rdv;
      c = classify(r, t);
      mask = (m_st <= 2'd1) ? 4'b0100 : (m_st == 2'd2) ? 4'b1000 : 4'b0000;
      it.chg = (c != m_st);
      if (rdv) begin m_stat = '0; m_pend = 1'b0; end
      if (it.chg) begin
         m_stat[16 + c] = 1'b1;
         if (mask[c]) m_pend = 1'b1;
      end
      m_stat[28:24] = m_stat[28:24] | f;
      m_st = c;
      it.st = m_st; it.stat = m_stat;
      it.irq = m_pend | (|m_stat[28:24]);
      it.cw = {7'd0, t[8:0], 8'd0, r[7:0]};
      exp_q.push_back(it);
      tag_q.push_back(req);
   endtask

   // monitor
   initial begin
      item_t it;
      string tg;
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk(tg, "state_chg", 32'(state_chg), 32'(it.chg));
            @(posedge clk);
            #1;
            chk(tg, "node_state", 32'(node_state), 32'(it.st));
            chk(tg, "status_word", status_word, it.stat);
            chk(tg, "irq", 32'(irq), 32'(it.irq));
            chk(tg, "err_cnt_word", err_cnt_word, it.cw);
         end
      end
   end

   initial begin
      #1ms;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "node_state", 32'(node_state), 32'd0);
      chk("R1", "status_word", status_word, 32'd0);
      chk("R1", "irq", 32'(irq), 32'd0);
      chk("R1", "state_chg", 32'(state_chg), 32'd0);
      step("R1", 0, 0, 5'd0, 1'b0);
      step("R2", 95, 95, 5'd0, 1'b0);
      step("R2", 96, 0, 5'd0, 1'b0);       // warning, no irq (R9)
      step("R5", 96, 0, 5'd0, 1'b0);       // no second pulse
      step("R2", 127, 127, 5'd0, 1'b0);
      step("R9", 0, 128, 5'd0, 1'b0);      // warning->passive, irq
      step("R8", 0, 128, 5'd0, 1'b1);      // read clears
      step("R3", 0, 255, 5'd0, 1'b0);
      step("R3", 0, 256, 5'd0, 1'b0);      // passive->bus-off, irq (R9)
      step("R8", 0, 256, 5'b00001, 1'b1);  // read with same-cycle event
      step("R10", 0, 256, 5'd0, 1'b1);     // clears irq
      step("R6", 0, 0, 5'd0, 1'b0);        // bus-off->active, no irq
      step("R8", 0, 0, 5'd0, 1'b1);
      step("R7", 0, 0, 5'b10101, 1'b0);
      step("R7", 0, 0, 5'b01010, 1'b0);
      step("R10", 0, 0, 5'd0, 1'b1);
      step("R9", 10, 300, 5'd0, 1'b0);     // active->bus-off, masked
      step("R4", 8'hA5, 9'h1C3, 5'd0, 1'b1);
      step("R6", 0, 0, 5'd0, 1'b1);
      step("R9", 200, 0, 5'd0, 1'b0);      // active->passive, irq
      step("R5", 200, 0, 5'd0, 1'b1);
      step("R2", 100, 20, 5'd0, 1'b0);     // passive->warning
      step("R4", 8'h5A, 9'h03C, 5'b10000, 1'b0);
      repeat (4) @(posedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule